// File: doc/BRIEF.md
# Two-Stage 8x8 Forward DCT Engine

This block computes the forward two-dimensional discrete cosine transform of 8x8 blocks of unsigned 8-bit pixels. It splits the 2D transform into sixteen 8-point transforms. First it transforms each of the eight columns and keeps the results in an intermediate matrix. Then it transforms each of the eight rows of that matrix. One 8-point kernel serves both passes. The kernel first forms the sum and the difference of each mirrored sample pair, x(i) and x(7-i). Each output coefficient is then a four-term dot product of those values with fixed cosine weights. The even outputs use only the sums and the odd outputs use only the differences.

Pixels enter as a valid/ready stream in raster order, 64 per block, and the block subtracts 128 from each one. A single multiply-accumulate unit is shared, so every coefficient takes four cycles. The block accepts no new pixels while it computes. Coefficients leave as a stream of one-cycle pulses in raster order of frequency (vertical frequency v selects the row, horizontal frequency u the column). A marker flags the last coefficient of each block. Each coefficient is a 12-bit signed value, rounded and saturated. Quantization and entropy coding take place further down the pipeline.

Top module: `dct8x8_engine`

## Requirements
- R1: After reset, in_ready is high and the block takes one pixel on each cycle where in_valid and in_ready are both high. Each pixel is level-shifted to pixel-128, so an all-128 block gives 64 coefficients within ±1 of zero.
- R2: On the clock edge that accepts the 64th pixel of a block, in_ready drops. It stays low for 512 cycles and rises on the 512th edge after that accepting edge.
- R3: Coefficient j (j = 8*v + u, 0..63) is presented with out_valid high for exactly one cycle, right after the (260 + 4*j)th clock edge following the accepting edge. No other cycle has out_valid high.
- R4: out_last is high together with out_valid for coefficient j = 63 and is low at all other times.
- R5: Each coefficient lies within ±1 of F(v,u) = 1/4 * C(u) * C(v) * sum over y,x of (p(y,x)-128) * cos((2y+1)vπ/16) * cos((2x+1)uπ/16), where C(0) = 1/√2 and C(k>0) = 1. Here p(y,x) is the pixel at row y and column x.
- R6: A block of constant pixel value c yields a first coefficient of 8*(c-128) ±1 and all other coefficients within ±1 of zero. For example, 255 gives 1016 and 0 gives -1024.
- R7: out_coef is 12-bit two's complement, saturated to [-2048, 2047]. For 8-bit inputs every value lies within [-1100, 1100].
- R8: The columns are transformed first. A block whose pixels vary only with the row index gives coefficients within ±1 of zero at every position with u ≠ 0.
- R9: While reset is asserted and before any input arrives, out_valid and out_last are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel on in_sample is valid |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_sample | input | 8 | Unsigned pixel, raster order |
| out_valid | output | 1 | out_coef carries a coefficient this cycle |
| out_coef | output | 12 | Signed DCT coefficient |
| out_last | output | 1 | Marks coefficient 63 of a block |

## Verification
The bound checker checks on every cycle:
- that in_ready drops right after the 64th accepted pixel;
- that output pulses never fall on two consecutive cycles;
- that out_last falls exactly on the 64th coefficient and coincides with in_ready returning;
- that coefficient values stay inside the range that 8-bit inputs allow.

Only the bench's scenarios can show the rest:
- numeric accuracy against a floating-point 2D transform;
- the exact cycle position of each coefficient;
- the level shift on constant blocks;
- the column-first orientation, using a block that varies only vertically;
- correct handling of pixels arriving with gaps between them.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;

    localparam int COEF_W    = 16;   // signed Q1.14 weights
    localparam int COEF_FRAC = 14;
    localparam int NPT       = 8;    // kernel length
    localparam int TAPS      = NPT / 2;

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_COLS = 2'd1,
        PH_ROWS = 2'd2
    } phase_e;

    // Weight for output k, tap i: C(k)/2 * cos((2i+1)k*pi/16) in Q1.14.
    function automatic logic signed [COEF_W-1:0] cos_tap(input logic [2:0] k,
                                                         input logic [1:0] i);
        int  ang;
        int  mag;
        logic neg;
        ang = ((2 * int'(i) + 1) * int'(k)) % 32;
        if (ang > 16) ang = 32 - ang;
        neg = (ang > 8);
        if (neg) ang = 16 - ang;
        case (ang)
            1:       mag = 8035;
            2:       mag = 7568;
            3:       mag = 6811;
            4:       mag = 5793;
            5:       mag = 4551;
            6:       mag = 3135;
            7:       mag = 1598;
            default: mag = 0;
        endcase
        if (k == 3'd0) begin
            mag = 5793;
            neg = 1'b0;
        end
        return neg ? COEF_W'(-mag) : COEF_W'(mag);
    endfunction

endpackage

// File: rtl/dct_regfile.sv
`timescale 1ns/1ps
module dct_regfile #(
    parameter int W     = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/dct_butterfly.sv
`timescale 1ns/1ps
module dct_butterfly #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    input  logic                diff_i,   // 1: a-b, 0: a+b
    output logic signed [W:0]   y_o
);

    logic signed [W:0] a_ext, b_ext;

    assign a_ext = {a_i[W-1], a_i};
    assign b_ext = {b_i[W-1], b_i};
    assign y_o   = diff_i ? (a_ext - b_ext) : (a_ext + b_ext);

endmodule

// File: rtl/dct_mac.sv
`timescale 1ns/1ps
module dct_mac #(
    parameter int IN_W  = 17,
    parameter int C_W   = 16,
    parameter int ACC_W = 40,
    localparam int P_W  = IN_W + C_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic                    first_i,
    input  logic signed [IN_W-1:0]  opnd_i,
    input  logic signed [C_W-1:0]   coef_i,
    output logic signed [ACC_W-1:0] sum_o
);

    logic signed [P_W-1:0]   prod;
    logic signed [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        prod  = opnd_i * coef_i;
        sum_o = (first_i ? '0 : acc_q) + {{(ACC_W-P_W){prod[P_W-1]}}, prod};
        acc_d = en_i ? sum_o : acc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

endmodule

// File: rtl/dct8x8_engine.sv
`timescale 1ns/1ps
module dct8x8_engine
    import dct_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int OUT_W    = 12,
    parameter int MID_W    = 16,
    parameter int MID_FRAC = 3,
    parameter int ACC_W    = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_coef,
    output logic                out_last
);

    localparam int BLK    = NPT * NPT;
    localparam int AW     = $clog2(BLK);
    localparam int STEP_W = $clog2(BLK * TAPS);
    localparam int OP_W   = MID_W + 1;
    localparam int SH_MID = COEF_FRAC - MID_FRAC;
    localparam int SH_OUT = COEF_FRAC + MID_FRAC;
    localparam logic signed [ACC_W-1:0] RND_MID = ACC_W'(1) << (SH_MID - 1);
    localparam logic signed [ACC_W-1:0] RND_OUT = ACC_W'(1) << (SH_OUT - 1);
    localparam logic signed [ACC_W-1:0] OMAX    = ACC_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] OMIN    = ~OMAX;

    typedef struct packed {
        phase_e             ph;
        logic [AW-1:0]      ld_cnt;
        logic [STEP_W-1:0]  step;
        logic               ovalid;
        logic               olast;
        logic [OUT_W-1:0]   ocoef;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [1:0] tap;
    logic [2:0] kidx, line;
    assign {line, kidx, tap} = c_q.step;

    // source pixel buffer (level-shifted)
    logic                src_we;
    logic [SAMPLE_W-1:0] src_a, src_b;
    logic [SAMPLE_W-1:0] shifted;
    assign shifted = {~in_sample[SAMPLE_W-1], in_sample[SAMPLE_W-2:0]};

    dct_regfile #(.W(SAMPLE_W), .DEPTH(BLK)) u_src (
        .clk    (clk),
        .we     (src_we),
        .waddr  (c_q.ld_cnt),
        .wdata  (shifted),
        .raddr_a({1'b0, tap, line}),
        .raddr_b({1'b1, ~tap, line}),
        .rdata_a(src_a),
        .rdata_b(src_b)
    );

    // transpose buffer: written per column, read per row
    logic             mid_we;
    logic [MID_W-1:0] mid_a, mid_b, mid_wdata;

    dct_regfile #(.W(MID_W), .DEPTH(BLK)) u_tbuf (
        .clk    (clk),
        .we     (mid_we),
        .waddr  ({kidx, line}),
        .wdata  (mid_wdata),
        .raddr_a({line, 1'b0, tap}),
        .raddr_b({line, 1'b1, ~tap}),
        .rdata_a(mid_a),
        .rdata_b(mid_b)
    );

    // kernel datapath
    logic signed [MID_W-1:0] op_a, op_b;
    logic signed [OP_W-1:0]  bfly;
    logic signed [ACC_W-1:0] mac_sum, mid_full, out_full;
    logic [OUT_W-1:0]        sat;

    always_comb begin
        if (c_q.ph == PH_COLS) begin
            op_a = {{(MID_W-SAMPLE_W){src_a[SAMPLE_W-1]}}, src_a};
            op_b = {{(MID_W-SAMPLE_W){src_b[SAMPLE_W-1]}}, src_b};
        end else begin
            op_a = mid_a;
            op_b = mid_b;
        end
    end

    dct_butterfly #(.W(MID_W)) u_bfly (
        .a_i   (op_a),
        .b_i   (op_b),
        .diff_i(kidx[0]),
        .y_o   (bfly)
    );

    dct_mac #(.IN_W(OP_W), .C_W(COEF_W), .ACC_W(ACC_W)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (c_q.ph != PH_LOAD),
        .first_i(tap == 2'd0),
        .opnd_i (bfly),
        .coef_i (cos_tap(kidx, tap)),
        .sum_o  (mac_sum)
    );

    always_comb begin
        mid_full  = (mac_sum + RND_MID) >>> SH_MID;
        out_full  = (mac_sum + RND_OUT) >>> SH_OUT;
        mid_wdata = mid_full[MID_W-1:0];
        if (out_full > OMAX)      sat = OUT_W'(OMAX);
        else if (out_full < OMIN) sat = OUT_W'(OMIN);
        else                      sat = out_full[OUT_W-1:0];
    end

    // control
    always_comb begin
        c_d        = c_q;
        c_d.ovalid = 1'b0;
        c_d.olast  = 1'b0;
        src_we     = 1'b0;
        mid_we     = 1'b0;
        unique case (c_q.ph)
            PH_LOAD: begin
                if (in_valid) begin
                    src_we     = 1'b1;
                    c_d.ld_cnt = c_q.ld_cnt + AW'(1);
                    if (c_q.ld_cnt == AW'(BLK - 1)) begin
                        c_d.ph   = PH_COLS;
                        c_d.step = '0;
                    end
                end
            end
            PH_COLS: begin
                mid_we   = (tap == 2'd3);
                c_d.step = c_q.step + STEP_W'(1);
                if (c_q.step == '1) c_d.ph = PH_ROWS;
            end
            PH_ROWS: begin
                if (tap == 2'd3) begin
                    c_d.ovalid = 1'b1;
                    c_d.ocoef  = sat;
                    c_d.olast  = (c_q.step == '1);
                end
                c_d.step = c_q.step + STEP_W'(1);
                if (c_q.step == '1) begin
                    c_d.ph     = PH_LOAD;
                    c_d.ld_cnt = '0;
                end
            end
            default: c_d.ph = PH_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.ph     <= PH_LOAD;
            c_q.ld_cnt <= '0;
            c_q.step   <= '0;
            c_q.ovalid <= 1'b0;
            c_q.olast  <= 1'b0;
            c_q.ocoef  <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign in_ready  = (c_q.ph == PH_LOAD);
    assign out_valid = c_q.ovalid;
    assign out_last  = c_q.olast;
    assign out_coef  = c_q.ocoef;

endmodule

// File: rtl/dct8x8_checker.sv
`timescale 1ns/1ps
module dct8x8_checker #(
    parameter int SAMPLE_W = 8,
    parameter int OUT_W    = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic                out_valid,
    input logic [OUT_W-1:0]    out_coef,
    input logic                out_last
);

    logic [5:0] acc_cnt_q, out_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt_q <= '0;
            out_cnt_q <= '0;
        end else begin
            if (in_valid && in_ready) acc_cnt_q <= acc_cnt_q + 6'd1;
            if (out_valid)            out_cnt_q <= out_cnt_q + 6'd1;
        end
    end

    // R2: the 64th accepted pixel closes the input
    p_busy_after_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && acc_cnt_q == 6'd63) |=> !in_ready);

    // R3: coefficients never arrive on adjacent cycles
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4: marker sits on the 64th coefficient only
    p_last_position_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (out_cnt_q == 6'd63)));

    p_last_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R2: input reopens together with the final coefficient
    p_reopen_with_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> in_ready);

    // R7: value range for 8-bit pixels
    p_coef_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_coef) <= 12'sd1100 && $signed(out_coef) >= -12'sd1100));

endmodule

bind dct8x8_engine dct8x8_checker #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_sample(in_sample),
    .out_valid(out_valid),
    .out_coef (out_coef),
    .out_last (out_last)
);

// File: tb/sim_dct8x8_engine.sv
`timescale 1ns/1ps
module sim_dct8x8_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_sample = 8'd0;
    logic       out_valid;
    logic [11:0] out_coef;
    logic       out_last;

    always #2 clk = ~clk;   // 250 MHz

    dct8x8_engine u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_sample(in_sample),
        .out_valid(out_valid),
        .out_coef (out_coef),
        .out_last (out_last)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    started  = 0;
    bit    done     = 0;
    int    phase    = -1;
    int    acc      = 0;
    int    cap [64];
    real   refv [64];
    string next_tag = "R5";
    int    next_mode = 0;
    string blk_tag  = "R5";
    int    blk_mode = 0;
    int    blocks_out = 0;
    localparam real PI = 3.14159265358979;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void build_ref();
        for (int v = 0; v < 8; v++) begin
            for (int u = 0; u < 8; u++) begin
                real s, cu, cv;
                s  = 0.0;
                cu = (u == 0) ? 0.70710678118 : 1.0;
                cv = (v == 0) ? 0.70710678118 : 1.0;
                for (int y = 0; y < 8; y++)
                    for (int x = 0; x < 8; x++)
                        s += real'(cap[y*8+x] - 128)
                             * $cos(real'((2*y+1)*v) * PI / 16.0)
                             * $cos(real'((2*x+1)*u) * PI / 16.0);
                refv[v*8+u] = 0.25 * cu * cv * s;
            end
        end
    endfunction

    // behavioural timeline: count edges since the accepting edge
    always @(posedge clk) begin
        if (!rst_n) begin
            phase = -1;
            acc   = 0;
        end else begin
            if (phase >= 0) phase = (phase >= 512) ? -1 : phase + 1;
            if (in_valid && in_ready) begin
                cap[acc] = int'(in_sample);
                if (acc == 63) begin
                    acc      = 0;
                    phase    = 0;
                    blk_tag  = next_tag;
                    blk_mode = next_mode;
                    build_ref();
                end else begin
                    acc = acc + 1;
                end
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && started) begin
            bit exp_ready, exp_valid;
            exp_ready = (phase < 0) || (phase >= 512);
            check(in_ready == exp_ready, "R2", "in_ready", int'(in_ready), int'(exp_ready));
            exp_valid = (phase >= 260) && (phase <= 512) && (((phase - 260) % 4) == 0);
            check(out_valid == exp_valid, "R3", "out_valid", int'(out_valid), int'(exp_valid));
            if (!exp_valid)
                check(out_last == 1'b0, "R4", "out_last idle", int'(out_last), 0);
            if (exp_valid && out_valid) begin
                int  j, got, rnd;
                real diff;
                j    = (phase - 260) / 4;
                got  = int'($signed(out_coef));
                rnd  = $rtoi(refv[j] + ((refv[j] >= 0.0) ? 0.5 : -0.5));
                diff = real'(got) - refv[j];
                if (diff < 0.0) diff = -diff;
                check(out_last == (j == 63), "R4", "out_last", int'(out_last), int'(j == 63));
                check(diff <= 1.0, blk_tag, $sformatf("coef %0d", j), got, rnd);
                if (blk_mode == 3 && (j % 8) != 0)
                    check(got >= -1 && got <= 1, "R8", $sformatf("coef %0d u!=0", j), got, 0);
                if (j == 63) blocks_out++;
            end
        end
    end

    function automatic int pix(input int mode, input int n, inout int unsigned seed);
        int y, x;
        y = n / 8;
        x = n % 8;
        case (mode)
            0: return 128;
            1: return 255;
            2: return 0;
            3: return 16 + 30 * y;
            4: return ((x + y) % 2) ? 255 : 0;
            5: return (20 * x + 10 * y) % 256;
            default: begin
                seed = seed * 32'd1103515245 + 32'd12345;
                return int'((seed >> 16) & 32'd255);
            end
        endcase
    endfunction

    task automatic send_block(input int mode, input string tag, input bit gaps,
                              inout int unsigned seed);
        int vals [64];
        for (int n = 0; n < 64; n++) vals[n] = pix(mode, n, seed);
        while (!in_ready) @(negedge clk);
        next_tag  = tag;
        next_mode = mode;
        for (int n = 0; n < 64; n++) begin
            if (gaps && (n % 5) == 2) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            while (!in_ready) @(negedge clk);
            in_valid  = 1'b1;
            in_sample = 8'(vals[n]);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd7;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
        check(out_last == 1'b0, "R9", "out_last in reset", int'(out_last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        started = 1;
        send_block(0, "R1", 1'b0, seed);   // all mid-grey
        send_block(1, "R6", 1'b0, seed);   // constant 255 -> 1016
        send_block(2, "R6", 1'b1, seed);   // constant 0 -> -1024
        send_block(3, "R8", 1'b0, seed);   // vertical-only variation
        send_block(4, "R5", 1'b1, seed);   // checkerboard
        send_block(5, "R5", 1'b0, seed);   // ramp
        for (int b = 0; b < 3; b++) send_block(6, "R5", (b % 2) == 1, seed);
        repeat (600) @(negedge clk);
        check(blocks_out == 9, "R3", "blocks completed", blocks_out, 9);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL R3 watchdog: actual=%0d expected=%0d", blocks_out, 9);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule